// File: doc/BRIEF.md
# GPIO Event Detect and Interrupt Unit

This block watches a set of general-purpose pins and latches an event into a sticky status bit for each pin. Each pin has its own set of event sources:

- rising edge and falling edge, both seen on the already-synchronized level;
- high level and low level, on the same synchronized level;
- rising edge and falling edge captured directly on the raw pin. The raw-pin capture still sees a pulse that starts and ends between two clock edges.

Any combination of sources can be enabled for a pin. Enabling rising and falling together detects both edges.

Pins are grouped in banks of 32. Each bank drives one interrupt line, which is high while any status bit of that bank is set. Software reads the status, services the pins, and clears bits by writing ones. An event that has been latched stays set after its enable is removed, until software clears it.

Access is through a simple 32-bit register port. Each register is one byte address: `group*8 + bank*4`. The groups are:

| Group | Register |
|-------|----------|
| 0 | status |
| 1 | rising enable |
| 2 | falling enable |
| 3 | high-level enable |
| 4 | low-level enable |
| 5 | raw rising enable |
| 6 | raw falling enable |

With the default of 54 pins, bank 0 holds pins 0..31 and bank 1 holds pins 32..53 in bits 0..21.

Top module: `gpio_evt_unit`

## Requirements
- R1: After reset, every enable register and every status bit is 0, both interrupt outputs are low, and all registers read 0.
- R2: With the rising (falling) enable set for a pin, its status bit is set at the first clock edge where the synchronized level is 1 (0) and the previous sample was 0 (1). An edge whose enable is clear sets nothing. With both enables set, both edges are detected.
- R3: Writing the status register clears each bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: A latched status bit stays set after its detect enable is cleared. It is removed only by a clear write.
- R5: If a clear write and a new event for the same bit happen in the same cycle, the bit ends up set.
- R6: With high-level (low-level) enable set, the status bit is set on every clock while the synchronized level is 1 (0). A clear during that time has no lasting effect. After the level leaves, or the enable is removed, a clear removes the bit.
- R7: With raw rising (falling) enable set, an edge on the raw pin sets the status bit at the third clock edge after it, even for a pulse shorter than a clock period. Raw edges whose enable is clear set nothing.
- R8: irq_o[b] is 1 exactly while at least one status bit of bank b is set. Pins 32..53 belong to bank 1.
- R9: Reads return data on rdata_o one clock edge after the request. Register byte address is group*8 + bank*4, with groups 0 status, 1 rising, 2 falling, 3 high, 4 low, 5 raw rising, 6 raw falling. Group 7 and unaligned addresses read 0.
- R10: Register bits above the last pin (bank 1 bits 22..31 by default) cannot be written and read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| pins_i | input | 54 | Synchronized pin levels |
| pins_raw_i | input | 54 | Unsynchronized pin levels for raw edge capture |
| irq_o | output | 2 | Per-bank interrupt |

## Verification
The results of this block arrive at different times:
- A synchronous edge or level event appears in status at the first rising clock edge after the pin changes.
- A register write takes effect at the edge that accepts it.
- Read data appears on rdata_o at the edge that accepts the read.
- A raw-pin edge lands in status at the third edge.

The bench changes pins and requests only on falling edges. It queues the expected read value when it issues a read, and a monitor compares that value one time unit after the capturing rising edge. Each status read is placed after the pin change with at least the latency above in between. Raw pulses are followed by five idle cycles before the read. The interrupt outputs are compared on falling edges, after the status they reflect has settled.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NUM_EN = 6;

  typedef enum logic [2:0] {
    GRP_STAT  = 3'd0,
    GRP_RISE  = 3'd1,
    GRP_FALL  = 3'd2,
    GRP_HIGH  = 3'd3,
    GRP_LOW   = 3'd4,
    GRP_ARISE = 3'd5,
    GRP_AFALL = 3'd6,
    GRP_NONE  = 3'd7
  } grp_e;

  // enable register index = group - 1
  localparam int unsigned EN_RISE  = 0;
  localparam int unsigned EN_FALL  = 1;
  localparam int unsigned EN_HIGH  = 2;
  localparam int unsigned EN_LOW   = 3;
  localparam int unsigned EN_ARISE = 4;
  localparam int unsigned EN_AFALL = 5;
endpackage

// File: rtl/gpio_evt_edge_sync.sv
module gpio_evt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic rise_o,
  output logic fall_o
);
  logic rt_q, ft_q;
  logic [STAGES:0] rs_q, fs_q;

  // toggle on each raw edge; no clear crosses back into the pin domain
  always_ff @(posedge raw_i or negedge rst_ni) begin
    if (!rst_ni) rt_q <= 1'b0;
    else         rt_q <= ~rt_q;
  end

  always_ff @(negedge raw_i or negedge rst_ni) begin
    if (!rst_ni) ft_q <= 1'b0;
    else         ft_q <= ~ft_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs_q <= '0;
      fs_q <= '0;
    end else begin
      rs_q <= {rs_q[STAGES-1:0], rt_q};
      fs_q <= {fs_q[STAGES-1:0], ft_q};
    end
  end

  assign rise_o = rs_q[STAGES] ^ rs_q[STAGES-1];
  assign fall_o = fs_q[STAGES] ^ fs_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int unsigned N = 54
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pins_i,
  input  logic [N-1:0] rise_en_i,
  input  logic [N-1:0] fall_en_i,
  input  logic [N-1:0] high_en_i,
  input  logic [N-1:0] low_en_i,
  output logic [N-1:0] ev_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pins_i;
  end

  always_comb begin
    ev_o = ( pins_i & ~prev_q & rise_en_i)
         | (~pins_i &  prev_q & fall_en_i)
         | ( pins_i &  high_en_i)
         | (~pins_i &  low_en_i);
  end
endmodule

// File: rtl/gpio_evt_cfg.sv
module gpio_evt_cfg
  import gpio_evt_pkg::*;
#(
  parameter int unsigned      PAD    = 64,
  parameter int unsigned      BANK_W = 1,
  parameter logic [PAD-1:0]   MASK   = '1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  grp_e                        grp_i,
  input  logic [PAD-1:0]              wmask_i,
  input  logic [PAD-1:0]              wval_i,
  output logic [NUM_EN-1:0][PAD-1:0]  en_o
);
  logic [NUM_EN-1:0][PAD-1:0] en_q;

  for (genvar e = 0; e < NUM_EN; e++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[e] <= '0;
      end else if (wr_i && grp_i == grp_e'(e + 1)) begin
        en_q[e] <= ((en_q[e] & ~wmask_i) | (wval_i & wmask_i)) & MASK;
      end
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 54,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [WORD_W-1:0]            wdata_i,
  output logic [WORD_W-1:0]            rdata_o,
  input  logic [NUM_PINS-1:0]          pins_i,
  input  logic [NUM_PINS-1:0]          pins_raw_i,
  output logic [(NUM_PINS+31)/32-1:0]  irq_o
);
  localparam int unsigned NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int unsigned BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int unsigned PAD       = NUM_BANKS * WORD_W;
  localparam int unsigned GRP_LSB   = 2 + BANK_W;
  localparam int unsigned TOP_LSB   = GRP_LSB + 3;
  localparam logic [PAD-1:0] MASK   = (PAD'(1) << NUM_PINS) - PAD'(1);

  // address decode
  grp_e              grp;
  logic [BANK_W-1:0] bank;
  logic              hit;
  logic              wr;
  logic [PAD-1:0]    wmask, wval;

  assign grp  = grp_e'(addr_i[GRP_LSB +: 3]);
  assign bank = addr_i[2 +: BANK_W];

  always_comb begin
    hit = (addr_i[1:0] == 2'b00) && (int'(bank) < NUM_BANKS);
    if (ADDR_W > TOP_LSB) hit = hit && ((addr_i >> TOP_LSB) == '0);
  end

  assign wr    = req_i && we_i && hit;
  assign wmask = PAD'({WORD_W{1'b1}}) << (int'(bank) * WORD_W);
  assign wval  = PAD'(wdata_i) << (int'(bank) * WORD_W);

  // enables
  logic [NUM_EN-1:0][PAD-1:0] en;

  gpio_evt_cfg #(
    .PAD   (PAD),
    .BANK_W(BANK_W),
    .MASK  (MASK)
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .grp_i  (grp),
    .wmask_i(wmask),
    .wval_i (wval),
    .en_o   (en)
  );

  // synchronous detection
  logic [NUM_PINS-1:0] sync_ev;

  gpio_evt_detect #(.N(NUM_PINS)) u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pins_i   (pins_i),
    .rise_en_i(en[EN_RISE][NUM_PINS-1:0]),
    .fall_en_i(en[EN_FALL][NUM_PINS-1:0]),
    .high_en_i(en[EN_HIGH][NUM_PINS-1:0]),
    .low_en_i (en[EN_LOW][NUM_PINS-1:0]),
    .ev_o     (sync_ev)
  );

  // raw-pin edge capture
  logic [NUM_PINS-1:0] async_ev;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_raw
    logic ar, af;
    gpio_evt_edge_sync #(.STAGES(SYNC_STAGES)) u_es (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (pins_raw_i[g]),
      .rise_o(ar),
      .fall_o(af)
    );
    assign async_ev[g] = (ar & en[EN_ARISE][g]) | (af & en[EN_AFALL][g]);
  end

  // sticky status, write one to clear, new event wins
  logic [PAD-1:0] ev_pad, clr_vec, status_q;

  assign ev_pad  = PAD'(sync_ev | async_ev);
  assign clr_vec = (wr && grp == GRP_STAT) ? (wval & wmask) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= ((status_q & ~clr_vec) | ev_pad) & MASK;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_irq
    assign irq_o[b] = |status_q[b*WORD_W +: WORD_W];
  end

  // readback
  logic [PAD-1:0]    sel_vec;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] rdata_q;

  always_comb begin
    unique case (grp)
      GRP_STAT:  sel_vec = status_q;
      GRP_RISE:  sel_vec = en[EN_RISE];
      GRP_FALL:  sel_vec = en[EN_FALL];
      GRP_HIGH:  sel_vec = en[EN_HIGH];
      GRP_LOW:   sel_vec = en[EN_LOW];
      GRP_ARISE: sel_vec = en[EN_ARISE];
      GRP_AFALL: sel_vec = en[EN_AFALL];
      default:   sel_vec = '0;
    endcase
    rd_word = hit ? WORD_W'(sel_vec >> (int'(bank) * WORD_W)) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_word;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/gpio_evt_unit_chk.sv
module gpio_evt_unit_chk #(
  parameter int unsigned PAD = 64
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [PAD-1:0] clr_i,
  input logic [PAD-1:0] ev_i,
  input logic [PAD-1:0] status_i
);
  // R3: cleared bits with no same-cycle event end up zero
  p_w1c_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((status_i & $past(clr_i) & ~$past(ev_i)) == '0));

  // R4: without a clear, a set bit stays set
  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((status_i & $past(status_i)) == $past(status_i)));

  // R5: an event sets its bit even against a clear
  p_event_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i != '0) |=> ((status_i & $past(ev_i)) == $past(ev_i)));

  // R2: a bit never rises without an event
  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((status_i & ~$past(status_i) & ~$past(ev_i)) == '0));
endmodule

bind gpio_evt_unit gpio_evt_unit_chk #(.PAD(PAD)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_i   (clr_vec),
  .ev_i    (ev_pad),
  .status_i(status_q)
);

// File: tb/sim_gpio_evt_unit.sv
module sim_gpio_evt_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 54;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pins = '0, raw = '0;
  logic [1:0]    irq;

  typedef struct {
    logic [31:0] d;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_evt_unit u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .req_i     (req),
    .we_i      (we),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .pins_i    (pins),
    .pins_raw_i(raw),
    .irq_o     (irq)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back('{e, tag});
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic [1:0] e, input string tag);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
    end
  endtask

  // monitor: compare read data after the capturing edge
  always @(posedge clk) begin
    if (rst_n && req && !we) begin
      exp_t x;
      #1;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R9 unexpected read actual=%h expected=none", rdata);
      end else begin
        x = exp_q.pop_front();
        if (rdata !== x.d) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", x.tag, rdata, x.d);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(8'h00, 32'h0, "R1 status0");
    rd(8'h04, 32'h0, "R1 status1");
    rd(8'h08, 32'h0, "R1 rise0");
    rd(8'h34, 32'h0, "R1 afall1");
    chk_irq(2'b00, "R1");

    // R10 padding bits, R9 unmapped
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h003F_FFFF, "R10 rise1 pad");
    wr(8'h0C, 32'h0);
    rd(8'h38, 32'h0, "R9 group7");
    rd(8'h09, 32'h0, "R9 unaligned");

    // R2 rising on pin0, falling on pin1
    wr(8'h08, 32'h1);
    wr(8'h10, 32'h2);
    pins[0] = 1'b1; idle(1);
    rd(8'h00, 32'h1, "R2 rise pin0");
    pins[1] = 1'b1; idle(1);
    rd(8'h00, 32'h1, "R2 rise ignored pin1");
    pins[1] = 1'b0; idle(1);
    rd(8'h00, 32'h3, "R2 fall pin1");
    chk_irq(2'b01, "R8 bank0");

    // R3 write-one-to-clear
    wr(8'h00, 32'h2);
    rd(8'h00, 32'h1, "R3 clear bit1");
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h1, "R3 zero write");

    // R4 sticky after disable
    wr(8'h08, 32'h0);
    rd(8'h00, 32'h1, "R4 sticky");
    wr(8'h00, 32'h1);
    rd(8'h00, 32'h0, "R4 cleared");
    chk_irq(2'b00, "R8 low");

    // R5 event wins over same-cycle clear
    wr(8'h08, 32'h1);
    pins[0] = 1'b0; idle(1);
    pins[0] = 1'b1; wr(8'h00, 32'h1);
    rd(8'h00, 32'h1, "R5 event wins");
    wr(8'h00, 32'h1);
    rd(8'h00, 32'h0, "R5 later clear");

    // R2 both edges on pin2
    wr(8'h08, 32'h5);
    wr(8'h10, 32'h6);
    pins[2] = 1'b1; idle(1);
    rd(8'h00, 32'h4, "R2 both rise");
    wr(8'h00, 32'h4);
    rd(8'h00, 32'h0, "R2 both cleared");
    pins[2] = 1'b0; idle(1);
    rd(8'h00, 32'h4, "R2 both fall");
    wr(8'h00, 32'h4);

    // R6 high level on pin35
    wr(8'h1C, 32'h8);
    rd(8'h1C, 32'h8, "R9 high1 readback");
    pins[35] = 1'b1; idle(1);
    rd(8'h04, 32'h8, "R6 high set");
    chk_irq(2'b10, "R8 bank1");
    wr(8'h04, 32'h8);
    rd(8'h04, 32'h8, "R6 clear no effect");
    pins[35] = 1'b0; idle(1);
    wr(8'h04, 32'h8);
    rd(8'h04, 32'h0, "R6 high gone");
    chk_irq(2'b00, "R8 bank1 low");

    // R6 low level on pin36 (already low)
    wr(8'h24, 32'h10);
    idle(1);
    rd(8'h04, 32'h10, "R6 low set");
    wr(8'h24, 32'h0);
    wr(8'h04, 32'h10);
    rd(8'h04, 32'h0, "R6 low disabled");

    // R7 raw rising short pulse on pin5
    wr(8'h28, 32'h20);
    raw[5] = 1'b1; #2; raw[5] = 1'b0;
    idle(5);
    rd(8'h00, 32'h20, "R7 raw rise");
    raw[6] = 1'b1; #2; raw[6] = 1'b0;
    idle(5);
    rd(8'h00, 32'h20, "R7 raw disabled");

    // R7 raw falling on pin40
    wr(8'h34, 32'h100);
    raw[40] = 1'b1;
    idle(5);
    rd(8'h04, 32'h0, "R7 raw rise not falling");
    raw[40] = 1'b0;
    idle(5);
    rd(8'h04, 32'h100, "R7 raw fall");
    chk_irq(2'b11, "R8 both");

    // R3 clear all
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0, "R3 clear all 0");
    rd(8'h04, 32'h0, "R3 clear all 1");
    chk_irq(2'b00, "R8 final");

    idle(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule